// File: doc/BRIEF.md
# Framebuffer Line Fetcher

The block pulls one frame of pixel data out of memory and hands it, beat by beat, to a pixel FIFO that the display side drains in its own clock domain. Software-visible settings arrive as plain inputs: the frame start address, the length of one line in bytes, the number of lines and a signed distance between consecutive line starts. The pitch is signed, so a frame can be walked upward or downward in memory. Each line is cut into read bursts of 8-byte beats. A request goes out on a simplified read-address channel only while the number of open requests is under the programmed limit and the FIFO can take the whole burst. The free-space count includes beats that are still on their way back.

A frame is started by a one-cycle `frame_start` pulse while `enable` is high. A one-cycle `underrun` pulse from the display side ends all fetching for the current frame. The block then drains the responses it still expects and throws them away. The next `frame_start` begins again at the frame start address. Dropping `enable` aborts the frame the same way. Two one-cycle flags report frame completion and read errors.

The controller has four states. IDLE waits for a start. FETCH issues bursts. FLUSH waits for the last responses once every burst is out. DRAIN discards responses after an abort. The transitions are as follows:
- start: IDLE to FETCH on `frame_start` with `enable` high.
- all_sent: FETCH to FLUSH once no burst remains.
- complete: FLUSH to IDLE when no request is open, which also raises the done flag.
- abort: FETCH or FLUSH to DRAIN on `underrun` or low `enable`.
- drained: DRAIN to IDLE when no request is open.

Top module: `fb_line_fetcher`

## Requirements
- R1: After reset, and whenever the block is in IDLE, `ar_valid`, `px_push` and both `irq` bits are 0.
- R2: Bursts within a line have consecutive addresses, 8 bytes per beat. The first line starts at `base_addr`, and every later line starts at the previous line start plus `line_pitch`, taken as a signed value with 32-bit wraparound.
- R3: Each burst carries min(burst limit, beats left in the line) beats, in the range 1 to 16, and no burst crosses into the next line. The burst limit is `bus_opts[4:0]`, with 0 read as 1 and values above 16 read as 16.
- R4: The number of issued requests whose last beat has not returned never exceeds `bus_opts[11:8]`, with 0 read as 1, while the options are held steady.
- R5: A request is issued only if `fifo_space` is at least the beats still in flight plus the beats of the new burst, so the FIFO never overflows.
- R6: Every error-free response beat in FETCH or FLUSH is pushed with `px_push`, in arrival order, with its data unchanged.
- R7: `irq[0]` pulses for exactly one cycle after all bursts of the frame have been issued and answered. A frame of zero lines or zero beats per line pulses it without issuing any request.
- R8: A response beat with `r_err` high pulses `irq[1]` in that cycle, and that beat is not pushed.
- R9: An `underrun` pulse stops all requests and pushes from that cycle on and suppresses `irq[0]` for that frame. The next `frame_start` fetches the whole frame again from `base_addr`.
- R10: Low `enable` aborts the frame like R9, and `frame_start` has no effect while `enable` is low.
- R11: The beats per line equal `line_bytes` divided by 8, with the low three bits ignored. `line_count` is 12 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Fetching allowed; low aborts the frame |
| frame_start | input | 1 | One-cycle pulse that begins a frame |
| underrun | input | 1 | One-cycle pulse from the display side |
| base_addr | input | 32 | Byte address of the first line |
| line_bytes | input | 16 | Bytes per line |
| line_count | input | 12 | Lines per frame |
| line_pitch | input | 32 | Signed byte step between line starts |
| bus_opts | input | 12 | [4:0] burst limit, [11:8] open request limit |
| fifo_space | input | 8 | Free FIFO entries of 8 bytes |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| ar_addr | output | 32 | Burst start address |
| ar_beats | output | 5 | Beats in the burst |
| r_valid | input | 1 | Response beat valid |
| r_data | input | 64 | Response beat data |
| r_last | input | 1 | Last beat of a burst |
| r_err | input | 1 | Response beat carries a bus error |
| px_push | output | 1 | Write strobe to the pixel FIFO |
| px_data | output | 64 | Data written to the pixel FIFO |
| irq | output | 2 | [0] frame fetched, [1] bus error (pulses) |

## Verification
The bench walks frames whose line lengths are not a multiple of the burst, whose pitch is negative, and whose burst and open-request limits sit at both extremes. A walker that let a burst spill into the next line, or that stepped lines by the line length instead of the pitch, shows up as a wrong address or beat count. A FIFO model with a slow reader catches a credit check that forgot beats in flight, because the model overflows. Underrun and disable are fired in the middle of a frame. A fetcher that kept issuing, pushed stale beats or still reported completion is caught there, and so is one that failed to restart at the base address or that finished early on an empty frame.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
    localparam int BEAT_BYTES    = 8;
    localparam int MAX_BURST     = 16;
    localparam int OPT_BURST_LSB = 0;
    localparam int OPT_OPEN_LSB  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FLUSH,
        ST_DRAIN
    } fbf_state_e;
endpackage

// File: rtl/fbf_walker.sv
module fbf_walker #(
    parameter int ADDR_W  = 32,
    parameter int BEATS_W = 13,
    parameter int LINES_W = 12,
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               advance,
    input  logic [ADDR_W-1:0]  base,
    input  logic [BEATS_W-1:0] line_beats,
    input  logic [LINES_W-1:0] line_count,
    input  logic [ADDR_W-1:0]  pitch,
    input  logic [BURST_W-1:0] burst_max,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [BURST_W-1:0] req_beats,
    output logic               all_issued
);
    localparam int BEAT_SHIFT = $clog2(fbf_pkg::BEAT_BYTES);

    logic [ADDR_W-1:0]  line_start, burst_addr, pitch_q, next_line;
    logic [BEATS_W-1:0] beats_q, beats_left;
    logic [LINES_W-1:0] lines_left;
    logic               line_end;

    always_comb begin
        if (beats_left < BEATS_W'(burst_max)) req_beats = BURST_W'(beats_left);
        else                                   req_beats = burst_max;
        line_end   = (beats_left == BEATS_W'(req_beats));
        next_line  = line_start + pitch_q;
        all_issued = (lines_left == '0);
        req_addr   = burst_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_start <= '0;
            burst_addr <= '0;
            pitch_q    <= '0;
            beats_q    <= '0;
            beats_left <= '0;
            lines_left <= '0;
        end else if (load) begin
            line_start <= base;
            burst_addr <= base;
            pitch_q    <= pitch;
            beats_q    <= line_beats;
            beats_left <= line_beats;
            lines_left <= (line_beats == '0) ? '0 : line_count;
        end else if (advance && !all_issued) begin
            if (line_end) begin
                line_start <= next_line;
                burst_addr <= next_line;
                beats_left <= beats_q;
                lines_left <= lines_left - LINES_W'(1);
            end else begin
                burst_addr <= burst_addr + (ADDR_W'(req_beats) << BEAT_SHIFT);
                beats_left <= beats_left - BEATS_W'(req_beats);
            end
        end
    end

    AST_BURST_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !all_issued |-> (req_beats != '0) && (BEATS_W'(req_beats) <= beats_left)); // R3
endmodule

// File: rtl/fbf_credit.sv
module fbf_credit #(
    parameter int OPEN_W  = 4,
    parameter int SPACE_W = 8,
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [BURST_W-1:0] ask_beats,
    input  logic               beat_rx,
    input  logic               last_rx,
    input  logic [OPEN_W-1:0]  open_max,
    input  logic [SPACE_W-1:0] fifo_space,
    output logic               can_issue,
    output logic               quiet
);
    localparam int INFL_W = SPACE_W + 1;
    localparam int SUM_W  = INFL_W + 1;

    logic [OPEN_W:0]   open_cnt, open_eff;
    logic [INFL_W-1:0] inflight;
    logic [SUM_W-1:0]  need;

    always_comb begin
        open_eff  = (open_max == '0) ? (OPEN_W+1)'(1) : (OPEN_W+1)'(open_max);
        need      = SUM_W'(inflight) + SUM_W'(ask_beats);
        can_issue = (open_cnt < open_eff) && (need <= SUM_W'(fifo_space));
        quiet     = (open_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_cnt <= '0;
            inflight <= '0;
        end else begin
            open_cnt <= open_cnt + (OPEN_W+1)'(issue) - (OPEN_W+1)'(last_rx);
            inflight <= inflight + (issue ? INFL_W'(ask_beats) : '0) - INFL_W'(beat_rx);
        end
    end

    AST_OPEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        open_cnt <= open_eff); // R4
    AST_CREDIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (inflight == '0)); // R5
endmodule

// File: rtl/fb_line_fetcher.sv
module fb_line_fetcher
    import fbf_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 16,
    parameter int LINES_W = 12,
    parameter int SPACE_W = 8,
    parameter int OPEN_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     frame_start,
    input  logic                     underrun,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [LEN_W-1:0]         line_bytes,
    input  logic [LINES_W-1:0]       line_count,
    input  logic signed [ADDR_W-1:0] line_pitch,
    input  logic [11:0]              bus_opts,
    input  logic [SPACE_W-1:0]       fifo_space,
    output logic                     ar_valid,
    input  logic                     ar_ready,
    output logic [ADDR_W-1:0]        ar_addr,
    output logic [4:0]               ar_beats,
    input  logic                     r_valid,
    input  logic [DATA_W-1:0]        r_data,
    input  logic                     r_last,
    input  logic                     r_err,
    output logic                     px_push,
    output logic [DATA_W-1:0]        px_data,
    output logic [1:0]               irq
);
    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
    localparam int BEATS_W    = LEN_W - BEAT_SHIFT;
    localparam int BURST_W    = $clog2(MAX_BURST) + 1;

    fbf_state_e         state_q, state_d;
    logic [BURST_W-1:0] burst_raw, burst_eff, req_beats;
    logic [ADDR_W-1:0]  req_addr;
    logic               abort, load, all_issued, can_issue, quiet, handshake;

    assign burst_raw = bus_opts[OPT_BURST_LSB +: BURST_W];
    assign burst_eff = (burst_raw == '0) ? BURST_W'(1) :
                       (burst_raw > BURST_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : burst_raw;
    assign abort     = !enable || underrun;
    assign load      = (state_q == ST_IDLE) && enable && frame_start;
    assign handshake = ar_valid && ar_ready;

    fbf_walker #(
        .ADDR_W(ADDR_W), .BEATS_W(BEATS_W), .LINES_W(LINES_W), .BURST_W(BURST_W)
    ) i_walker (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(handshake),
        .base(base_addr), .line_beats(line_bytes[LEN_W-1:BEAT_SHIFT]),
        .line_count(line_count), .pitch(line_pitch), .burst_max(burst_eff),
        .req_addr(req_addr), .req_beats(req_beats), .all_issued(all_issued)
    );

    fbf_credit #(
        .OPEN_W(OPEN_W), .SPACE_W(SPACE_W), .BURST_W(BURST_W)
    ) i_credit (
        .clk(clk), .rst_n(rst_n), .issue(handshake), .ask_beats(req_beats),
        .beat_rx(r_valid), .last_rx(r_valid && r_last),
        .open_max(bus_opts[OPT_OPEN_LSB +: OPEN_W]), .fifo_space(fifo_space),
        .can_issue(can_issue), .quiet(quiet)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_FETCH;
            ST_FETCH: if (abort) state_d = ST_DRAIN;
                      else if (all_issued) state_d = ST_FLUSH;
            ST_FLUSH: if (abort) state_d = ST_DRAIN;
                      else if (quiet) state_d = ST_IDLE;
            ST_DRAIN: if (quiet) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ar_valid = (state_q == ST_FETCH) && !abort && !all_issued && can_issue;
        ar_addr  = req_addr;
        ar_beats = req_beats;
        px_push  = r_valid && !r_err && !abort &&
                   ((state_q == ST_FETCH) || (state_q == ST_FLUSH));
        px_data  = r_data;
        irq[0]   = (state_q == ST_FLUSH) && !abort && quiet;
        irq[1]   = r_valid && r_err;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !ar_valid && !px_push); // R1
    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_beats >= 5'd1) && (ar_beats <= 5'(MAX_BURST))); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |=> !irq[0]); // R7
    AST_DRAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> !ar_valid && !px_push && !irq[0]); // R9
endmodule

// File: tb/test_fb_line_fetcher.sv
module test_fb_line_fetcher;
    localparam int DEPTH = 32;
    localparam int NV    = 5;
    localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h8000, 32'h2000, 32'h0000, 32'h10000};
    localparam int          V_BYTES[NV] = '{64, 106, 136, 24, 256};
    localparam int          V_LINES[NV] = '{3, 2, 3, 4, 2};
    localparam int          V_PITCH[NV] = '{256, -512, 136, 64, 512};
    localparam logic [11:0] V_OPTS [NV] = '{12'h408, 12'h204, 12'h11F, 12'hF01, 12'h810};

    logic clk = 0, rst_n = 0, enable = 0, frame_start = 0, underrun = 0;
    logic [31:0] base_addr = '0, line_pitch = '0;
    logic [15:0] line_bytes = '0;
    logic [11:0] line_count = '0, bus_opts = '0;
    logic [7:0]  fifo_space = 8'(DEPTH);
    logic        ar_valid, ar_ready = 0, r_valid = 0, r_last = 0, r_err = 0, px_push;
    logic [31:0] ar_addr;
    logic [4:0]  ar_beats;
    logic [63:0] r_data = '0, px_data;
    logic [1:0]  irq;

    always #5 clk = ~clk;

    fb_line_fetcher i_fb_line_fetcher (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
        .underrun(underrun), .base_addr(base_addr), .line_bytes(line_bytes),
        .line_count(line_count), .line_pitch(line_pitch), .bus_opts(bus_opts),
        .fifo_space(fifo_space), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .ar_addr(ar_addr), .ar_beats(ar_beats), .r_valid(r_valid), .r_data(r_data),
        .r_last(r_last), .r_err(r_err), .px_push(px_push), .px_data(px_data), .irq(irq)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] exp_addr[256];
    int          exp_bt[256];
    logic [31:0] exp_data[1024];
    int n_exp = 0, n_beats = 0, got_req = 0, got_beat = 0, hs_cnt = 0;
    int done_cnt = 0, err_cnt = 0, err_at = -1, resp_total = 0;
    logic [31:0] q_addr[64];
    int q_bt[64];
    int q_head = 0, q_tail = 0, beat_i = 0, wait_cnt = 0;
    int outs = 0, max_outs = 0, occ = 0, max_occ = 0, abort_viol = 0;
    bit seq_on = 0, data_on = 0, aborted = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int eff_burst(input logic [11:0] o);
        int r = int'(o[4:0]);
        return (r == 0) ? 1 : ((r > 16) ? 16 : r);
    endfunction

    function automatic int eff_open(input logic [11:0] o);
        return (o[11:8] == 4'd0) ? 1 : int'(o[11:8]);
    endfunction

    task automatic gen_exp(input logic [31:0] b, input int bytes, input int lines,
                           input int pitch, input logic [11:0] o);
        logic [31:0] ls = b;
        n_exp = 0; n_beats = 0;
        for (int l = 0; l < lines; l++) begin
            logic [31:0] a = ls;
            int left = bytes / 8;
            while (left > 0) begin
                int bb = (left < eff_burst(o)) ? left : eff_burst(o);
                exp_addr[n_exp] = a; exp_bt[n_exp] = bb; n_exp++;
                for (int k = 0; k < bb; k++) begin
                    exp_data[n_beats] = a + 32'(k * 8); n_beats++;
                end
                a = a + 32'(bb * 8); left -= bb;
            end
            ls = ls + 32'(pitch);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (q_head != q_tail && wait_cnt >= 3) begin
            r_valid = 1;
            r_last  = (beat_i == q_bt[q_head % 64] - 1);
            r_data  = {32'h0, q_addr[q_head % 64] + 32'(beat_i * 8)};
            r_err   = (resp_total == err_at);
        end else begin
            r_valid = 0; r_last = 0; r_err = 0;
        end
        fifo_space = 8'(DEPTH - occ);
        ar_ready   = (cyc % 4 != 3);
        #1;
        if (ar_valid && ar_ready) begin
            hs_cnt++;
            if (aborted) abort_viol++;
            if (seq_on) begin
                if (got_req < n_exp) begin
                    chk(ar_addr == exp_addr[got_req], "R2 burst address", ar_addr, exp_addr[got_req]);
                    chk(int'(ar_beats) == exp_bt[got_req], "R3 burst beats", ar_beats, exp_bt[got_req]);
                end else chk(0, "R3 extra request", got_req, n_exp);
                got_req++;
            end
            q_addr[q_tail % 64] = ar_addr; q_bt[q_tail % 64] = int'(ar_beats); q_tail++;
            outs++;
            if (outs > max_outs) max_outs = outs;
        end
        if (px_push) begin
            occ++;
            if (occ > max_occ) max_occ = occ;
            if (aborted) abort_viol++;
            if (seq_on && data_on && got_beat < n_beats)
                chk(px_data == {32'h0, exp_data[got_beat]}, "R6 pushed data", px_data, {32'h0, exp_data[got_beat]});
            got_beat++;
        end
        if (irq[0]) done_cnt++;
        if (irq[1]) err_cnt++;
        if (r_valid) begin
            resp_total++;
            if (r_last) begin q_head++; beat_i = 0; wait_cnt = 0; outs--; end
            else beat_i++;
        end else if (q_head != q_tail) wait_cnt++;
        if (cyc % 2 == 0 && occ > 0) occ--;
        cyc++;
    endtask

    task automatic setup(input logic [31:0] b, input int bytes, input int lines,
                         input int pitch, input logic [11:0] o);
        base_addr = b; line_bytes = 16'(bytes); line_count = 12'(lines);
        line_pitch = 32'(pitch); bus_opts = o;
        gen_exp(b, bytes, lines, pitch, o);
        got_req = 0; got_beat = 0; done_cnt = 0; err_cnt = 0; resp_total = 0;
        max_outs = 0; max_occ = 0; hs_cnt = 0; abort_viol = 0;
    endtask

    task automatic run_frame(input logic [31:0] b, input int bytes, input int lines,
                             input int pitch, input logic [11:0] o, input int errb);
        int n = 0;
        setup(b, bytes, lines, pitch, o);
        err_at = errb; seq_on = 1; data_on = (errb < 0);
        frame_start = 1; step(); frame_start = 0;
        while (done_cnt == 0 && n < 4000) begin step(); n++; end
        repeat (6) step();
        chk(done_cnt == 1, "R7 frame done pulses", done_cnt, 1);
        chk(got_req == n_exp, "R3 request count", got_req, n_exp);
        if (errb < 0) chk(got_beat == n_beats, "R6 beats pushed", got_beat, n_beats);
        else begin
            chk(err_cnt == 1, "R8 error flag pulses", err_cnt, 1);
            chk(got_beat == n_beats - 1, "R8 error beat dropped", got_beat, n_beats - 1);
        end
        chk(max_outs <= eff_open(o), "R4 open requests", max_outs, eff_open(o));
        chk(max_occ <= DEPTH, "R5 fifo occupancy", max_occ, DEPTH);
        seq_on = 0; err_at = -1;
    endtask

    task automatic abort_test(input bit by_underrun);
        setup(32'h4000, 64, 16, 64, 12'h204);
        frame_start = 1; step(); frame_start = 0;
        repeat (25) step();
        chk(hs_cnt > 0, "R9 fetch started before abort", hs_cnt, 1);
        aborted = 1; done_cnt = 0;
        if (by_underrun) begin underrun = 1; step(); underrun = 0; end
        else enable = 0;
        repeat (120) step();
        if (by_underrun) begin
            chk(abort_viol == 0, "R9 activity after underrun", abort_viol, 0);
            chk(done_cnt == 0, "R9 no done after underrun", done_cnt, 0);
        end else begin
            chk(abort_viol == 0, "R10 activity after disable", abort_viol, 0);
            chk(done_cnt == 0, "R10 no done after disable", done_cnt, 0);
            frame_start = 1; step(); frame_start = 0;
            repeat (20) step();
            chk(abort_viol == 0, "R10 start ignored while disabled", abort_viol, 0);
            enable = 1;
        end
        chk(q_head == q_tail, "R9 responses drained", q_tail - q_head, 0);
        aborted = 0;
    endtask

    initial begin
        #(150000 * 10);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(ar_valid == 0, "R1 reset ar_valid", ar_valid, 0);
        chk(px_push == 0, "R1 reset px_push", px_push, 0);
        chk(irq == 2'b00, "R1 reset irq", irq, 0);
        rst_n = 1; enable = 1;
        step();
        // R2 R3 R4 R5 R6 R11: table of frame shapes
        for (int v = 0; v < NV; v++)
            run_frame(V_BASE[v], V_BYTES[v], V_LINES[v], V_PITCH[v], V_OPTS[v], -1);
        // R7: empty frames finish with no request
        run_frame(32'h3000, 64, 0, 64, 12'h408, -1);
        run_frame(32'h3000, 4, 3, 64, 12'h408, -1);   // R11 sub-beat line
        // R8: error on the sixth response beat
        run_frame(32'h5000, 64, 2, 128, 12'h408, 5);
        // R9: underrun, then a full frame from the base again
        abort_test(1);
        run_frame(32'h4000, 64, 2, 64, 12'h204, -1);
        // R10: disable, then re-enabled frame from the base
        abort_test(0);
        run_frame(32'h4000, 64, 2, -64, 12'h204, -1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule